// File: doc/BRIEF.md
# Floating-Point Condition Code Unit

This block keeps the four 2-bit floating-point condition code fields of a status register, together with a small current-exception field. A compare unit elsewhere delivers its outcome as a 2-bit result code plus a few side flags. The block decides whether the compare raises the invalid exception. It then writes the code into the addressed field, unless the exception is set to trap.

In the other direction, a conditional floating-point move asks whether its predicate holds. The query names one of the four fields and a 4-bit condition. The block answers combinationally from the registered fields. A query whose predicate is false behaves as a no-op that clears the current-exception field. The move datapath and the compare arithmetic sit outside this block. The full status word is brought out so that the surrounding logic can read it.

Top module: `fcc_unit`

## Requirements
- R1: After reset every bit of `stat_o` is zero and `inv_o` is low.
- R2: A compare written while `cmp_vld_i` is high places `cmp_res_i` into the addressed field, visible on `stat_o` from the next clock. Field 0 sits at bits 11:10 and fields 1, 2 and 3 sit at bits 33:32, 35:34 and 37:36. Result codes are equal=0, less=1, greater=2 and unordered=3.
- R3: On a compare, the three fields that are not addressed keep their values.
- R4: For the signaling compare variant (`cmp_sig_i`=1), `inv_o` is high in the compare cycle exactly when the result code is 3 (unordered).
- R5: For the quiet variant (`cmp_sig_i`=0), `inv_o` is high in the compare cycle exactly when either operand is flagged as a signaling NaN. Without a valid compare, `inv_o` is low.
- R6: When a compare raises invalid while `inv_trap_en_i` is high, the addressed field is not written.
- R7: When a compare raises invalid, the current-exception field (`stat_o[4:0]`) becomes 5'b10000 (invalid is bit 4), whether or not the exception traps. A compare that raises nothing clears that field.
- R8: With condition bit 3 low, `pred_o` tests the selected field value v according to the low three bits: 0 never, 1 v≠0, 2 v is 1 or 2, 3 v bit 0 set, 4 v=1, 5 v bit 1 set, 6 v=2, 7 v=3.
- R9: Condition bit 3 inverts the result of R8, so 8 means always.
- R10: A query (`qry_vld_i`=1) whose predicate is false clears the current-exception field on the next clock. A query whose predicate is true leaves the status unchanged.
- R11: When a compare and a query arrive in the same cycle, the query is evaluated against the field values held before the write. The compare's update of the current-exception field takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_vld_i | input | 1 | Compare result valid |
| cmp_fld_i | input | 2 | Condition field written by the compare |
| cmp_res_i | input | 2 | Compare result code |
| cmp_sig_i | input | 1 | Compare is the signaling variant |
| cmp_snan_a_i | input | 1 | First operand is a signaling NaN |
| cmp_snan_b_i | input | 1 | Second operand is a signaling NaN |
| inv_trap_en_i | input | 1 | Invalid exception traps when raised |
| qry_vld_i | input | 1 | Conditional-move query valid |
| qry_fld_i | input | 2 | Condition field tested by the query |
| qry_cond_i | input | 4 | Query condition |
| pred_o | output | 1 | Predicate result |
| inv_o | output | 1 | Compare raises invalid |
| stat_o | output | 38 | Status word with fields and current exceptions |

## Verification
The embedded properties watch the following on every cycle:
- the write of an untrapped result into its field;
- that untouched fields and trapped fields hold their values;
- the two invalid rules;
- the clear after a false predicate;
- the always condition.

Only the bench's sweeps can show the following:
- the full predicate table across all sixteen conditions and all four field values;
- the exact bit placement of each field in the status word;
- the ordering when a compare and a query collide in one cycle.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        FCC_EQ = 2'd0,
        FCC_LT = 2'd1,
        FCC_GT = 2'd2,
        FCC_UN = 2'd3
    } fcc_code_e;

    localparam int FCC_W = 2;

    // Low bit of condition field k: field 0 sits apart, the rest are packed upward.
    function automatic int fld_lsb(input int k, input int lo0, input int hi_base);
        return (k == 0) ? lo0 : hi_base + FCC_W * (k - 1);
    endfunction

endpackage

// File: rtl/fcc_inv_gen.sv
module fcc_inv_gen
    import fcc_pkg::*;
(
    input  logic             sig_i,
    input  logic [FCC_W-1:0] res_i,
    input  logic             snan_a_i,
    input  logic             snan_b_i,
    output logic             inv_o
);

    always_comb begin
        if (sig_i) begin
            inv_o = (res_i == FCC_UN);
        end else begin
            inv_o = snan_a_i | snan_b_i;
        end
    end

endmodule

// File: rtl/fcc_fld_sel.sv
module fcc_fld_sel
    import fcc_pkg::*;
#(
    parameter int NUM_FLD   = 4,
    localparam int IDX_W    = $clog2(NUM_FLD)
) (
    input  logic [NUM_FLD-1:0][FCC_W-1:0] flds_i,
    input  logic [IDX_W-1:0]              idx_i,
    output logic [FCC_W-1:0]              fld_o
);

    always_comb begin
        fld_o = '0;
        for (int k = 0; k < NUM_FLD; k++) begin
            if (idx_i == IDX_W'(k)) begin
                fld_o = flds_i[k];
            end
        end
    end

endmodule

// File: rtl/fcc_pred_eval.sv
module fcc_pred_eval
    import fcc_pkg::*;
#(
    parameter int COND_W = 4
) (
    input  logic [FCC_W-1:0]  fcc_i,
    input  logic [COND_W-1:0] cond_i,
    output logic              pred_o
);

    logic base;

    always_comb begin
        unique case (cond_i[2:0])
            3'd0:    base = 1'b0;
            3'd1:    base = (fcc_i != FCC_EQ);
            3'd2:    base = (fcc_i == FCC_LT) || (fcc_i == FCC_GT);
            3'd3:    base = fcc_i[0];
            3'd4:    base = (fcc_i == FCC_LT);
            3'd5:    base = fcc_i[1];
            3'd6:    base = (fcc_i == FCC_GT);
            default: base = (fcc_i == FCC_UN);
        endcase
        pred_o = base ^ cond_i[3];
    end

endmodule

// File: rtl/fcc_unit.sv
module fcc_unit
    import fcc_pkg::*;
#(
    parameter int NUM_FLD   = 4,
    parameter int STAT_W    = 38,
    parameter int FLD0_LSB  = 10,
    parameter int FLDN_BASE = 32,
    parameter int CEXC_W    = 5,
    parameter int INV_BIT   = 4,
    parameter int COND_W    = 4,
    localparam int IDX_W    = $clog2(NUM_FLD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_vld_i,
    input  logic [IDX_W-1:0]  cmp_fld_i,
    input  logic [FCC_W-1:0]  cmp_res_i,
    input  logic              cmp_sig_i,
    input  logic              cmp_snan_a_i,
    input  logic              cmp_snan_b_i,
    input  logic              inv_trap_en_i,
    input  logic              qry_vld_i,
    input  logic [IDX_W-1:0]  qry_fld_i,
    input  logic [COND_W-1:0] qry_cond_i,
    output logic              pred_o,
    output logic              inv_o,
    output logic [STAT_W-1:0] stat_o
);

    localparam logic [CEXC_W-1:0] INV_MASK = CEXC_W'(1) << INV_BIT;

    typedef struct packed {
        logic [NUM_FLD-1:0][FCC_W-1:0] fcc;
        logic [CEXC_W-1:0]             cexc;
    } st_t;

    st_t  st_d, st_q;
    logic inv_raw;
    logic [FCC_W-1:0] qry_fcc;
    logic pred;

    fcc_inv_gen u_inv (
        .sig_i    (cmp_sig_i),
        .res_i    (cmp_res_i),
        .snan_a_i (cmp_snan_a_i),
        .snan_b_i (cmp_snan_b_i),
        .inv_o    (inv_raw)
    );

    fcc_fld_sel #(.NUM_FLD(NUM_FLD)) u_sel (
        .flds_i (st_q.fcc),
        .idx_i  (qry_fld_i),
        .fld_o  (qry_fcc)
    );

    fcc_pred_eval #(.COND_W(COND_W)) u_pred (
        .fcc_i  (qry_fcc),
        .cond_i (qry_cond_i),
        .pred_o (pred)
    );

    assign pred_o = pred;
    assign inv_o  = cmp_vld_i & inv_raw;

    always_comb begin
        st_d = st_q;
        if (qry_vld_i && !pred) begin
            st_d.cexc = '0;
        end
        if (cmp_vld_i) begin
            if (inv_raw) begin
                st_d.cexc = INV_MASK;
                if (!inv_trap_en_i) begin
                    st_d.fcc[cmp_fld_i] = cmp_res_i;
                end
            end else begin
                st_d.cexc = '0;
                st_d.fcc[cmp_fld_i] = cmp_res_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_o = '0;
        stat_o[CEXC_W-1:0] = st_q.cexc;
        for (int k = 0; k < NUM_FLD; k++) begin
            stat_o[fld_lsb(k, FLD0_LSB, FLDN_BASE) +: FCC_W] = st_q.fcc[k];
        end
    end

    // R2
    fld_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld_i && !(inv_o && inv_trap_en_i)) |=> st_q.fcc[$past(cmp_fld_i)] == $past(cmp_res_i));

    // R4
    sig_unord_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld_i && cmp_sig_i && cmp_res_i == FCC_UN) |-> inv_o);

    // R5
    quiet_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld_i && !cmp_sig_i) |-> (inv_o == (cmp_snan_a_i || cmp_snan_b_i)));

    // R7
    cexc_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld_i && inv_o) |=> st_q.cexc == INV_MASK);

    // R9
    always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_cond_i == COND_W'(8)) |-> pred_o);

    // R10
    false_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_vld_i && !pred_o && !cmp_vld_i) |=> st_q.cexc == '0);

    for (genvar k = 0; k < NUM_FLD; k++) begin : g_hold
        // R3
        other_fld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmp_vld_i || cmp_fld_i != IDX_W'(k)) |=> $stable(st_q.fcc[k]));

        // R6
        trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_vld_i && cmp_fld_i == IDX_W'(k) && inv_o && inv_trap_en_i) |=> $stable(st_q.fcc[k]));
    end

endmodule

// File: tb/fcc_unit_tb_top.sv
module fcc_unit_tb_top;

    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmp_vld_i, cmp_sig_i, cmp_snan_a_i, cmp_snan_b_i, inv_trap_en_i;
    logic [1:0]  cmp_fld_i, cmp_res_i, qry_fld_i;
    logic        qry_vld_i;
    logic [3:0]  qry_cond_i;
    logic        pred_o, inv_o;
    logic [37:0] stat_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [1:0] m_fcc [4];
    logic [4:0] m_cexc;

    always #(CLK_PER/2) clk = ~clk;

    fcc_unit dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmp_vld_i     (cmp_vld_i),
        .cmp_fld_i     (cmp_fld_i),
        .cmp_res_i     (cmp_res_i),
        .cmp_sig_i     (cmp_sig_i),
        .cmp_snan_a_i  (cmp_snan_a_i),
        .cmp_snan_b_i  (cmp_snan_b_i),
        .inv_trap_en_i (inv_trap_en_i),
        .qry_vld_i     (qry_vld_i),
        .qry_fld_i     (qry_fld_i),
        .qry_cond_i    (qry_cond_i),
        .pred_o        (pred_o),
        .inv_o         (inv_o),
        .stat_o        (stat_o)
    );

    function automatic logic [37:0] exp_stat();
        logic [37:0] s = '0;
        s[4:0]   = m_cexc;
        s[11:10] = m_fcc[0];
        s[33:32] = m_fcc[1];
        s[35:34] = m_fcc[2];
        s[37:36] = m_fcc[3];
        return s;
    endfunction

    function automatic logic exp_pred(input logic [1:0] v, input logic [3:0] c);
        logic b;
        case (c[2:0])
            3'd0: b = 1'b0;
            3'd1: b = (v != 2'd0);
            3'd2: b = (v == 2'd1) || (v == 2'd2);
            3'd3: b = v[0];
            3'd4: b = (v == 2'd1);
            3'd5: b = v[1];
            3'd6: b = (v == 2'd2);
            default: b = (v == 2'd3);
        endcase
        return b ^ c[3];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmp(input int f, input int r, input bit sig, input bit sa,
                          input bit sb, input bit trap);
        logic inv_e;
        @(negedge clk);
        cmp_vld_i = 1'b1; cmp_fld_i = 2'(f); cmp_res_i = 2'(r);
        cmp_sig_i = sig; cmp_snan_a_i = sa; cmp_snan_b_i = sb; inv_trap_en_i = trap;
        inv_e = sig ? (r == 3) : (sa | sb);
        #1;
        chk(sig ? "R4 inv" : "R5 inv", 64'(inv_o), 64'(inv_e));
        @(posedge clk);
        #1;
        cmp_vld_i = 1'b0;
        if (inv_e) begin
            m_cexc = 5'b10000;
            if (!trap) m_fcc[f] = 2'(r);
        end else begin
            m_cexc = 5'b0;
            m_fcc[f] = 2'(r);
        end
        chk(trap && inv_e ? "R6 R7 status" : "R2 R3 R7 status", 64'(stat_o), 64'(exp_stat()));
    endtask

    task automatic do_qry(input int f, input int c);
        logic pe;
        @(negedge clk);
        qry_vld_i = 1'b1; qry_fld_i = 2'(f); qry_cond_i = 4'(c);
        pe = exp_pred(m_fcc[f], 4'(c));
        #1;
        chk(c[3] ? "R9 pred" : "R8 pred", 64'(pred_o), 64'(pe));
        @(posedge clk);
        #1;
        qry_vld_i = 1'b0;
        if (!pe) m_cexc = 5'b0;
        chk("R10 status", 64'(stat_o), 64'(exp_stat()));
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cmp_vld_i = 0; cmp_fld_i = 0; cmp_res_i = 0; cmp_sig_i = 0;
        cmp_snan_a_i = 0; cmp_snan_b_i = 0; inv_trap_en_i = 0;
        qry_vld_i = 0; qry_fld_i = 0; qry_cond_i = 0;
        for (int k = 0; k < 4; k++) m_fcc[k] = 2'd0;
        m_cexc = 5'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk("R1 reset stat", 64'(stat_o), 64'd0);
        chk("R1 reset inv", 64'(inv_o), 64'd0);

        // Compare sweep: every field, result, variant, NaN flags and trap enable
        for (int trap = 0; trap < 2; trap++)
            for (int f = 0; f < 4; f++)
                for (int r = 0; r < 4; r++)
                    for (int sig = 0; sig < 2; sig++)
                        for (int sn = 0; sn < 4; sn++)
                            do_cmp(f, (r + f + sn) % 4, sig[0], sn[0], sn[1], trap[0]);

        // Predicate sweep: load each value with a pending invalid, then all conditions
        for (int f = 0; f < 4; f++)
            for (int v = 0; v < 4; v++) begin
                do_cmp(f, v, 1'b0, 1'b1, 1'b0, 1'b0);
                for (int c = 0; c < 16; c++) do_qry(f, c);
            end

        // R11: compare and query in one cycle
        do_cmp(2, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        cmp_vld_i = 1'b1; cmp_fld_i = 2'd2; cmp_res_i = 2'd1; cmp_sig_i = 1'b0;
        cmp_snan_a_i = 1'b1; cmp_snan_b_i = 1'b0; inv_trap_en_i = 1'b0;
        qry_vld_i = 1'b1; qry_fld_i = 2'd2; qry_cond_i = 4'd4;
        #1;
        chk("R11 pred uses old field", 64'(pred_o), 64'd0);
        @(posedge clk);
        #1;
        cmp_vld_i = 1'b0; qry_vld_i = 1'b0;
        m_fcc[2] = 2'd1; m_cexc = 5'b10000;
        chk("R11 compare wins", 64'(stat_o), 64'(exp_stat()));

        #1;
        chk("R5 idle inv", 64'(inv_o), 64'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule